// File: doc/BRIEF.md
# GPIO Pad Controller with Event Interrupts

This block is one GPIO community: a configurable number of pads, each with its own 32-bit configuration word, grouped into banks of up to 32 pads. Software reaches it over a simple 32-bit register bus with word addresses. A read or write request is accepted in one cycle, and `busReady` answers on the following cycle with the read data. Each pad drives an output level taken from its configuration word. Each pad's input passes through a two-flop synchroniser, and the synchronised level can be read back.

Every pad can raise an event. An inversion bit is applied before detection, and a two-bit selector chooses among level, single-edge and both-edge detection. Events latch into a per-bank sticky status word whether or not they are enabled. A per-bank enable word masks the status into a single combined interrupt line for the host. Software clears status bits by writing ones.

Top module: `gpio_community`

## Requirements
- R1: After reset every configuration word, status word and enable word reads zero, every pad output is low and `irq` is low.
- R2: Every bit of a pad configuration word except bit 1 reads back exactly as written. Bit 0 drives that pad's `padOut` bit.
- R3: Bit 1 of a pad configuration word reads the pad input after a two-flop synchroniser. A read issued one cycle after the input changes still returns the old level.
- R4: With the event selector (bits 26:25) at 00, the status bit sets on every cycle in which the effective input (input XOR bit 23) is high. A status bit cleared while the condition holds reads back set.
- R5: With selector 01, the status bit sets only on a rising edge of the effective input. With bit 23 set, this makes it a falling-edge detector on the pin.
- R6: With selector 11, the status bit sets on either edge of the input.
- R7: The status word of bank b sits at byte address 0x100+4b (word 0x40+b). Writing a 1 clears a bit, writing a 0 leaves it unchanged, and an event in the same cycle as a clear keeps the bit set.
- R8: The enable word of bank b sits at byte address 0x120+4b (word 0x48+b). Bits for pads that do not exist read zero. `irq` is high exactly when some bank has a bit set in both status and enable, so a status bit that is set but not enabled leaves `irq` low.
- R9: A read-only register at byte address 0x00C (word 3) returns 0x400, the byte offset of pad 0's configuration word. Pad n's word sits at byte 0x400+16n (word 0x100+4n).
- R10: Reads of unmapped word addresses return zero, and writes to them change no register.
- R11: `busReady` is high in exactly the cycle after a read or write request.
- R12: Selector 10 produces no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Word address |
| busRd | input | 1 | Read request |
| busWr | input | 1 | Write request |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Request completed |
| padIn | input | NUM_PADS | Raw pad inputs |
| padOut | output | NUM_PADS | Pad output levels |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a write-1-to-clear that lands in the same cycle as a fresh event on the same bit. An edge event would have to be timed to the exact cycle through the synchroniser. The stimulus avoids that by holding a pad in level mode with its input high, so an event arrives on every cycle and every clear collides with one. Another hard point is proving that disabled status is ignored. The bench does this by watching `irq` while the status bit is readable as set and its enable bit is off.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int IDX_W  = 8;
  localparam int BANK_W = 3;
  localparam int OUT_BIT = 0;
  localparam int IN_BIT  = 1;
  localparam int INV_BIT = 23;
  localparam int EV_LO   = 25;
  localparam int EV_HI   = 26;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_BASE, SEL_CFG, SEL_STS, SEL_EN
  } rdSel_e;

  typedef struct packed {
    logic              rdReq;
    rdSel_e            rdSel;
    logic              cfgWr;
    logic              stsWr;
    logic              enWr;
    logic [IDX_W-1:0]  pad;
    logic [BANK_W-1:0] bank;
  } strobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PADS  = 40,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 10,
  parameter int BASE_WORD = 3,
  parameter int STS_WORD  = 'h40,
  parameter int EN_WORD   = 'h48,
  parameter int CFG_WORD  = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output logic              ready,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_WORD);
  localparam logic [ADDR_W-1:0] STS_LO = ADDR_W'(STS_WORD);
  localparam logic [ADDR_W-1:0] STS_HI = ADDR_W'(STS_WORD + NUM_BANKS);
  localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_WORD);
  localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_WORD + NUM_BANKS);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_WORD);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_WORD + 4 * NUM_PADS);

  logic inCfg, inSts, inEn, inBase;
  logic [ADDR_W-1:0] relCfg, relSts, relEn;

  always_comb begin
    relCfg = addr - CFG_LO;
    relSts = addr - STS_LO;
    relEn  = addr - EN_LO;
    inBase = (addr == BASE_A);
    inSts  = (addr >= STS_LO) && (addr < STS_HI);
    inEn   = (addr >= EN_LO) && (addr < EN_HI);
    inCfg  = (addr >= CFG_LO) && (addr < CFG_HI) && (relCfg[1:0] == 2'b00);

    stb.rdReq = rdEn;
    stb.cfgWr = wrEn && inCfg;
    stb.stsWr = wrEn && inSts;
    stb.enWr  = wrEn && inEn;
    stb.pad   = IDX_W'(relCfg >> 2);
    stb.bank  = inSts ? BANK_W'(relSts) : BANK_W'(relEn);
    if (inBase)     stb.rdSel = SEL_BASE;
    else if (inCfg) stb.rdSel = SEL_CFG;
    else if (inSts) stb.rdSel = SEL_STS;
    else if (inEn)  stb.rdSel = SEL_EN;
    else            stb.rdSel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ready <= 1'b0;
    else        ready <= rdEn || wrEn;
  end

  assert_ready_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn || wrEn) |=> ready);
  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdEn || wrEn) |=> !ready);
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_PADS  = 40,
  parameter int NUM_BANKS = 2,
  parameter int BASE_BYTE = 'h400
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [31:0]         wdata,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [31:0]         rdata,
  output logic                irq
);
  logic [31:0] cfgQ [NUM_PADS];
  logic [NUM_PADS-1:0] sync1, sync2, prevQ, evt;
  logic [NUM_BANKS-1:0][31:0] stsQ, enQ, evtBank, validMask;
  logic [31:0] rdVal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prevQ <= '0;
    end else begin
      sync1 <= padIn;
      sync2 <= sync1;
      prevQ <= sync2;
    end
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic effNow, effOld;
    always_ff @(posedge clk) begin
      if (!rst_n) cfgQ[p] <= '0;
      else if (stb.cfgWr && stb.pad == IDX_W'(p))
        cfgQ[p] <= wdata & ~(32'h1 << IN_BIT);
    end
    assign padOut[p] = cfgQ[p][OUT_BIT];
    assign effNow = sync2[p] ^ cfgQ[p][INV_BIT];
    assign effOld = prevQ[p] ^ cfgQ[p][INV_BIT];
    always_comb begin
      case (cfgQ[p][EV_HI:EV_LO])
        2'b00:   evt[p] = effNow;
        2'b01:   evt[p] = effNow & ~effOld;
        2'b11:   evt[p] = effNow ^ effOld;
        default: evt[p] = 1'b0;
      endcase
    end

    assert_both_edge_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfgQ[p][EV_HI:EV_LO] == 2'b11 && sync2[p] == prevQ[p]) |-> !evt[p]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar i = 0; i < 32; i++) begin : g_bit
      if (b * 32 + i < NUM_PADS) begin : g_on
        assign evtBank[b][i]   = evt[b * 32 + i];
        assign validMask[b][i] = 1'b1;
      end else begin : g_off
        assign evtBank[b][i]   = 1'b0;
        assign validMask[b][i] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stsQ[b] <= '0;
        enQ[b]  <= '0;
      end else begin
        if (stb.stsWr && stb.bank == BANK_W'(b))
          stsQ[b] <= (stsQ[b] & ~wdata) | evtBank[b];
        else
          stsQ[b] <= stsQ[b] | evtBank[b];
        if (stb.enWr && stb.bank == BANK_W'(b))
          enQ[b] <= wdata & validMask[b];
      end
    end

    assert_event_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evtBank[b] != '0) |=> ((stsQ[b] & $past(evtBank[b])) == $past(evtBank[b])));
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.stsWr && stb.bank == BANK_W'(b)) |=>
        ((stsQ[b] & $past(wdata & ~evtBank[b])) == '0));
  end

  assign irq = |(stsQ & enQ);

  always_comb begin
    rdVal = '0;
    case (stb.rdSel)
      SEL_BASE: rdVal = 32'(BASE_BYTE);
      SEL_CFG: begin
        for (int p = 0; p < NUM_PADS; p++) begin
          if (stb.pad == IDX_W'(p)) begin
            rdVal = cfgQ[p];
            rdVal[IN_BIT] = sync2[p];
          end
        end
      end
      SEL_STS: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (stb.bank == BANK_W'(b)) rdVal = stsQ[b];
      end
      SEL_EN: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (stb.bank == BANK_W'(b)) rdVal = enQ[b];
      end
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata <= '0;
    else if (stb.rdReq) rdata <= rdVal;
    else                rdata <= '0;
  end

  assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdReq && stb.rdSel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/gpio_community.sv
module gpio_community
  import gpio_pkg::*;
#(
  parameter int NUM_PADS = 40,
  parameter int ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busReady,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic                irq
);
  localparam int NUM_BANKS = (NUM_PADS + 31) / 32;
  localparam int BASE_WORD = 3;
  localparam int STS_WORD  = 'h40;
  localparam int EN_WORD   = 'h48;
  localparam int CFG_WORD  = 'h100;
  localparam int CFG_BYTE  = CFG_WORD * 4;

  strobe_t stb;

  gpio_ctrl #(
    .NUM_PADS(NUM_PADS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
    .BASE_WORD(BASE_WORD), .STS_WORD(STS_WORD), .EN_WORD(EN_WORD),
    .CFG_WORD(CFG_WORD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(busAddr), .rdEn(busRd), .wrEn(busWr),
    .ready(busReady), .stb(stb)
  );

  gpio_datapath #(
    .NUM_PADS(NUM_PADS), .NUM_BANKS(NUM_BANKS), .BASE_BYTE(CFG_BYTE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(busWdata), .padIn(padIn),
    .padOut(padOut), .rdata(busRdata), .irq(irq)
  );
endmodule

// File: tb/gpio_community_test.sv
`timescale 1ns/100ps
module gpio_community_test;
  localparam int NP = 40;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busReady;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic wasRead = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  gpio_community #(.NUM_PADS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .padIn(padIn), .padOut(padOut), .irq(irq)
  );

  always @(posedge clk) wasRead <= busRd;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (wasRead && rst_n) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected read", busRdata, 32'h0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(busReady === 1'b1, {it.tag, " ready"}, {31'h0, busReady}, 32'h1);
        check(busRdata === it.exp, it.tag, busRdata, it.exp);
      end
    end
  end

  task automatic doRead(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    expQ.push_back(it);
    busAddr = a;
    busRd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d);
    busAddr = a;
    busWdata = d;
    busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finishRun();
  end

  localparam logic [AW-1:0] W_BASE = 10'h003;
  localparam logic [AW-1:0] W_STS0 = 10'h040;
  localparam logic [AW-1:0] W_STS1 = 10'h041;
  localparam logic [AW-1:0] W_EN0  = 10'h048;
  localparam logic [AW-1:0] W_EN1  = 10'h049;

  function automatic logic [AW-1:0] cfgAddr(input int n);
    return AW'(32'h100 + 4 * n);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    doRead(cfgAddr(0), 32'h0, "R1 cfg0");
    doRead(W_STS0, 32'h0, "R1 sts0");
    doRead(W_EN0, 32'h0, "R1 en0");
    check(irq === 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    check(padOut === '0, "R1 padOut", 32'(padOut), 32'h0);

    // R2 read-back and output drive
    doWrite(cfgAddr(5), 32'hFFFF_FFFF);
    doRead(cfgAddr(5), 32'hFFFF_FFFD, "R2 readback");
    check(padOut[5] === 1'b1, "R2 padOut high", {31'h0, padOut[5]}, 32'h1);
    doWrite(cfgAddr(5), 32'h0);
    check(padOut[5] === 1'b0, "R2 padOut low", {31'h0, padOut[5]}, 32'h0);

    // R3 synchroniser delay
    padIn[5] = 1'b1;
    @(negedge clk);
    doRead(cfgAddr(5), 32'h0, "R3 early");
    settle();
    doRead(cfgAddr(5), 32'h2, "R3 synced");

    // R4 level mode, clear collides with event; R8 disabled status ignored
    doRead(W_STS0, 32'h20, "R4 level set");
    check(irq === 1'b0, "R8 disabled ignored", {31'h0, irq}, 32'h0);
    doWrite(W_STS0, 32'h20);
    doRead(W_STS0, 32'h20, "R4 R7 event wins clear");
    padIn[5] = 1'b0;
    settle();
    doWrite(W_STS0, 32'h20);
    doRead(W_STS0, 32'h0, "R7 clear");

    // R5 single edge, then inverted
    doWrite(cfgAddr(0), 32'h0200_0000);
    padIn[0] = 1'b1; settle();
    doRead(W_STS0, 32'h1, "R5 rising");
    doWrite(W_STS0, 32'h1);
    doRead(W_STS0, 32'h0, "R5 no repeat");
    padIn[0] = 1'b0; settle();
    doRead(W_STS0, 32'h0, "R5 falling ignored");
    doWrite(cfgAddr(0), 32'h0280_0000);
    padIn[0] = 1'b1; settle();
    doRead(W_STS0, 32'h0, "R5 inv rising ignored");
    padIn[0] = 1'b0; settle();
    doRead(W_STS0, 32'h1, "R5 inv falling");
    doWrite(W_STS0, 32'h0);
    doRead(W_STS0, 32'h1, "R7 write zero keeps");
    doWrite(W_STS0, 32'h1);
    doRead(W_STS0, 32'h0, "R7 cleared");

    // R6 both edges on pad 33 (bank 1 bit 1)
    doWrite(cfgAddr(33), 32'h0600_0000);
    padIn[33] = 1'b1; settle();
    doRead(W_STS1, 32'h2, "R6 rise");
    doWrite(W_STS1, 32'h2);
    doRead(W_STS1, 32'h0, "R6 cleared");
    padIn[33] = 1'b0; settle();
    doRead(W_STS1, 32'h2, "R6 fall");
    doWrite(W_STS1, 32'h2);

    // R12 selector 10 silent on pad 39
    doWrite(cfgAddr(39), 32'h0400_0000);
    padIn[39] = 1'b1; settle();
    doRead(W_STS1, 32'h0, "R12 high");
    padIn[39] = 1'b0; settle();
    doRead(W_STS1, 32'h0, "R12 low");

    // R8 enable and combined interrupt
    doWrite(W_EN1, 32'hFFFF_FFFF);
    doRead(W_EN1, 32'h0000_00FF, "R8 valid bits");
    check(irq === 1'b0, "R8 no status", {31'h0, irq}, 32'h0);
    padIn[33] = 1'b1; settle();
    check(irq === 1'b1, "R8 irq high", {31'h0, irq}, 32'h1);
    doWrite(W_EN1, 32'h0);
    check(irq === 1'b0, "R8 masked", {31'h0, irq}, 32'h0);
    doRead(W_STS1, 32'h2, "R8 status kept");
    doWrite(W_EN1, 32'h2);
    check(irq === 1'b1, "R8 re-enabled", {31'h0, irq}, 32'h1);
    doWrite(W_STS1, 32'h2);
    check(irq === 1'b0, "R8 cleared", {31'h0, irq}, 32'h0);

    // R9 base register
    doRead(W_BASE, 32'h400, "R9 base");

    // R10 unmapped
    doRead(10'h101, 32'h0, "R10 misaligned");
    doRead(10'h042, 32'h0, "R10 no bank");
    doWrite(10'h04A, 32'hFFFF_FFFF);
    doRead(W_EN0, 32'h0, "R10 write ignored");
    doWrite(10'h005, 32'h1234_5678);
    doRead(W_BASE, 32'h400, "R10 base intact");

    // R11 ready lasts one cycle
    doRead(W_BASE, 32'h400, "R11 read");
    @(negedge clk);
    check(busReady === 1'b0, "R11 ready drops", {31'h0, busReady}, 32'h0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11 all reads answered", 32'(expQ.size()), 32'h0);
    finishRun();
  end
endmodule